// File: doc/BRIEF.md
# Biphase-Mark Stereo Audio Line Formatter

The formatter turns a stream of stereo PCM sample pairs into a self-clocking IEC958 (S/PDIF) line. A frame holds two subframes, left first and then right. Each subframe is 32 bit slots long, and each slot is sent as two line half-cells. The formatter runs entirely from a half-cell tick supplied by an external clock divider. That tick runs at 128 times the sample rate, so the same logic serves 32, 44.1, 48 or 96 kHz streams without change.

Every subframe opens with a synchronising preamble that breaks the coding rule on purpose. The preamble marks one of three cases: the start of a 192-frame block, an ordinary left subframe, or a right subframe. After the preamble come the audio word, a validity flag and a user flag taken from host configuration bits, one channel-status bit, and an even-parity bit. The channel-status bit is picked from a constant status word by a frame counter that runs from 0 to 191. Samples arrive through a valid/ready handshake into a one-pair holding register. If no new pair has arrived when a frame begins, the previous pair is sent again and no error is raised.

Top module: `bmc_frame_tx`

## Requirements
- R1: While reset is asserted and after its release, until the first tick, `line_out` is 0 and `pcm_ready` is 1.
- R2: Each cycle with `line_tick` high emits exactly one half-cell. A frame is 128 ticks: 64 for the left subframe, then 64 for the right. Slots 0 to 3 of each subframe are the preamble.
- R3: Let p be the line level just before a subframe. Its first 8 half-cells, in emission order, are the pattern XOR p. The patterns are: 11101000 for the left subframe of frame 0 of each block, 11100010 for every other left subframe, and 11100100 for every right subframe.
- R4: In slots 4 to 31 the line level inverts at the start of every cell. It inverts again at mid-cell exactly when the slot's bit is 1.
- R5: The sample is placed left-justified at 24 bits. Slot 4+i carries bit i of that 24-bit word, so the least significant bit goes first. The left subframe carries the left sample of the active pair, and the right subframe carries the right sample.
- R6: Slot 28 carries `cfg_valid` and slot 29 carries `cfg_user` in both subframes.
- R7: Slot 30 carries `cs_word[n]` for frame number n < CS_W, and 0 for other frames. The frame number counts 0 to 191 and then wraps to 0.
- R8: Slot 31 makes the count of ones over slots 4 to 31 even.
- R9: `pcm_ready` is 1 exactly when the holding register is empty. A pair taken on `pcm_valid && pcm_ready` becomes active at the first tick of the next frame. `pcm_ready` returns to 1 right after that tick.
- R10: If no pair is held when a frame begins, the active pair stays the same and is sent again. Before the first accepted pair, the active pair is all zeros.
- R11: In a cycle without `line_tick`, `line_out` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_tick | input | 1 | Half-cell clock enable (128 x Fs) |
| cfg_user | input | 1 | User flag inserted in slot 29 |
| cfg_valid | input | 1 | Validity flag inserted in slot 28 |
| cs_word | input | CS_W | Constant channel-status word, bit n used in frame n |
| pcm_valid | input | 1 | Sample pair offered |
| pcm_ready | output | 1 | Holding register empty |
| pcm_left | input | SAMPLE_W | Left sample |
| pcm_right | input | SAMPLE_W | Right sample |
| line_out | output | 1 | Biphase-mark coded serial line |

## Verification
Several rules are checked by assertions on every cycle: the inversion at each data cell boundary, the line holding still between ticks, and the channel alternating at each subframe end. They also check that the block counter wraps after frame 191, that the line level returns to its starting value after both the preamble and the parity bit, and that held samples and the ready flag behave as the handshake requires. What only the bench scenarios can show is the content itself: which preamble pattern each subframe gets, the bit order of the payload, the flag and status bits per frame, and which sample pair is active in a frame after irregular handshakes and stretches with no new data. The bench shows this by decoding the line and comparing it with a model.

// File: rtl/bmc_pkg.sv
package bmc_pkg;

  localparam int SLOTS     = 32;
  localparam int PRE_SLOTS = 4;
  localparam int BLOCK_LEN = 192;
  localparam int FRM_W     = 8;
  localparam int WORD_W    = 24;

  typedef enum logic [1:0] {
    PRE_BLOCK = 2'd0,
    PRE_LEFT  = 2'd1,
    PRE_RIGHT = 2'd2
  } pre_kind_e;

  // level pattern for a zero previous level, first half-cell in bit 7
  function automatic logic [7:0] pre_pattern(input pre_kind_e kind);
    case (kind)
      PRE_BLOCK: pre_pattern = 8'b1110_1000;
      PRE_LEFT:  pre_pattern = 8'b1110_0010;
      default:   pre_pattern = 8'b1110_0100;
    endcase
  endfunction

endpackage

// File: rtl/bmc_slot_seq.sv
module bmc_slot_seq
  import bmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  output logic             half,
  output logic [4:0]       slot,
  output logic             chan,
  output logic [FRM_W-1:0] frame,
  output logic             frame_start
);

  logic             half_n;
  logic [4:0]       slot_n;
  logic             chan_n;
  logic [FRM_W-1:0] frame_n;
  logic             last_half;

  assign last_half   = half && (slot == 5'(SLOTS - 1));
  assign frame_start = adv && !half && (slot == 5'd0) && !chan;

  always_comb begin
    half_n  = half;
    slot_n  = slot;
    chan_n  = chan;
    frame_n = frame;
    if (adv) begin
      half_n = ~half;
      if (half) begin
        slot_n = slot + 5'd1;
        if (last_half) begin
          chan_n = ~chan;
          if (chan) begin
            frame_n = (frame == FRM_W'(BLOCK_LEN - 1)) ? '0 : frame + 1'b1;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half  <= 1'b0;
      slot  <= '0;
      chan  <= 1'b0;
      frame <= '0;
    end else begin
      half  <= half_n;
      slot  <= slot_n;
      chan  <= chan_n;
      frame <= frame_n;
    end
  end

  // R7
  frame_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && last_half && chan && frame == FRM_W'(BLOCK_LEN - 1)) |=> (frame == '0));

  // R2
  chan_alt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && last_half) |=> (chan != $past(chan)));

endmodule

// File: rtl/bmc_sample_hold.sv
module bmc_sample_hold #(
  parameter int SAMPLE_W = 24
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] in_left,
  input  logic [SAMPLE_W-1:0] in_right,
  output logic [SAMPLE_W-1:0] act_left,
  output logic [SAMPLE_W-1:0] act_right
);

  logic                hold_full, hold_full_n;
  logic [SAMPLE_W-1:0] hold_l, hold_l_n, hold_r, hold_r_n;
  logic [SAMPLE_W-1:0] act_l_n, act_r_n;
  logic                take;

  assign in_ready = !hold_full;
  assign take     = in_valid && in_ready;

  always_comb begin
    hold_full_n = hold_full;
    hold_l_n    = hold_l;
    hold_r_n    = hold_r;
    act_l_n     = act_left;
    act_r_n     = act_right;
    if (load && hold_full) begin
      act_l_n     = hold_l;
      act_r_n     = hold_r;
      hold_full_n = 1'b0;
    end
    if (take) begin
      hold_l_n    = in_left;
      hold_r_n    = in_right;
      hold_full_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_full <= 1'b0;
      hold_l    <= '0;
      hold_r    <= '0;
      act_left  <= '0;
      act_right <= '0;
    end else begin
      hold_full <= hold_full_n;
      hold_l    <= hold_l_n;
      hold_r    <= hold_r_n;
      act_left  <= act_l_n;
      act_right <= act_r_n;
    end
  end

  // R9
  accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  // R9
  hold_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && !load) |=> ($stable(hold_l) && $stable(hold_r)));

  // R10
  act_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load) |=> ($stable(act_left) && $stable(act_right)));

endmodule

// File: rtl/bmc_subframe_word.sv
module bmc_subframe_word
  import bmc_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CS_W     = 32
) (
  input  logic [4:0]          slot,
  input  logic                chan,
  input  logic [FRM_W-1:0]    frame,
  input  logic [SAMPLE_W-1:0] act_left,
  input  logic [SAMPLE_W-1:0] act_right,
  input  logic                flag_user,
  input  logic                flag_valid,
  input  logic [CS_W-1:0]     cs_word,
  output logic                slot_bit
);

  localparam int PAD = WORD_W - SAMPLE_W;

  logic [WORD_W-1:0]    aligned;
  logic [BLOCK_LEN-1:0] cs_full;
  logic                 cs_bit;
  logic [SLOTS-1:0]     word;

  generate
    if (PAD > 0) begin : g_pad
      always_comb aligned = {(chan ? act_right : act_left), {PAD{1'b0}}};
    end else begin : g_nopad
      always_comb aligned = chan ? act_right : act_left;
    end
  endgenerate

  assign cs_full = BLOCK_LEN'(cs_word);
  assign cs_bit  = cs_full[frame];

  always_comb begin
    word         = '0;
    word[27:4]   = aligned;
    word[28]     = flag_valid;
    word[29]     = flag_user;
    word[30]     = cs_bit;
    word[31]     = ^word[30:4];
    slot_bit     = word[slot];
  end

endmodule

// File: rtl/bmc_line_enc.sv
module bmc_line_enc
  import bmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      tick,
  input  logic      half,
  input  logic [4:0] slot,
  input  pre_kind_e kind,
  input  logic      data_bit,
  output logic      line
);

  logic       line_n;
  logic       pol_q, pol_n, pol_use;
  logic [7:0] pat;
  logic [2:0] idx;
  logic       in_pre;

  assign pat    = pre_pattern(kind);
  assign idx    = {slot[1:0], half};
  assign in_pre = (slot < 5'(PRE_SLOTS));

  always_comb begin
    line_n  = line;
    pol_n   = pol_q;
    pol_use = (slot == 5'd0 && !half) ? line : pol_q;
    if (tick) begin
      if (in_pre) begin
        pol_n  = pol_use;
        line_n = pat[3'd7 - idx] ^ pol_use;
      end else if (!half) begin
        line_n = ~line;
      end else begin
        line_n = line ^ data_bit;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line  <= 1'b0;
      pol_q <= 1'b0;
    end else begin
      line  <= line_n;
      pol_q <= pol_n;
    end
  end

  // R4
  cell_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !in_pre && !half) |=> (line != $past(line)));

  // R11
  idle_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick) |=> $stable(line));

  // R3
  pre_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && slot == 5'd3 && half) |=> (line == pol_q));

  // R8
  sub_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && slot == 5'(SLOTS - 1) && half) |=> (line == pol_q));

endmodule

// File: rtl/bmc_frame_tx.sv
module bmc_frame_tx
  import bmc_pkg::*;
#(
  parameter int SAMPLE_W = 24,
  parameter int CS_W     = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                line_tick,
  input  logic                cfg_user,
  input  logic                cfg_valid,
  input  logic [CS_W-1:0]     cs_word,
  input  logic                pcm_valid,
  output logic                pcm_ready,
  input  logic [SAMPLE_W-1:0] pcm_left,
  input  logic [SAMPLE_W-1:0] pcm_right,
  output logic                line_out
);

  logic [1:0]          rst_sync;
  logic                rst_core_n;
  logic                half, chan, frame_start, slot_bit;
  logic [4:0]          slot;
  logic [FRM_W-1:0]    frame;
  logic [SAMPLE_W-1:0] act_l, act_r;
  pre_kind_e           kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_core_n = rst_sync[1];

  bmc_slot_seq u_seq (
    .clk(clk), .rst_n(rst_core_n), .adv(line_tick),
    .half(half), .slot(slot), .chan(chan), .frame(frame),
    .frame_start(frame_start)
  );

  bmc_sample_hold #(.SAMPLE_W(SAMPLE_W)) u_hold (
    .clk(clk), .rst_n(rst_core_n), .load(frame_start),
    .in_valid(pcm_valid), .in_ready(pcm_ready),
    .in_left(pcm_left), .in_right(pcm_right),
    .act_left(act_l), .act_right(act_r)
  );

  bmc_subframe_word #(.SAMPLE_W(SAMPLE_W), .CS_W(CS_W)) u_word (
    .slot(slot), .chan(chan), .frame(frame),
    .act_left(act_l), .act_right(act_r),
    .flag_user(cfg_user), .flag_valid(cfg_valid),
    .cs_word(cs_word), .slot_bit(slot_bit)
  );

  always_comb begin
    if (chan)              kind = PRE_RIGHT;
    else if (frame == '0)  kind = PRE_BLOCK;
    else                   kind = PRE_LEFT;
  end

  bmc_line_enc u_enc (
    .clk(clk), .rst_n(rst_core_n), .tick(line_tick),
    .half(half), .slot(slot), .kind(kind),
    .data_bit(slot_bit), .line(line_out)
  );

endmodule

// File: tb/test_bmc_frame_tx.sv
module test_bmc_frame_tx;

  localparam int CLK_PERIOD = 10;
  localparam int SW         = 24;
  localparam int CSW        = 32;
  localparam int N_FRAMES   = 200;
  localparam int WATCHDOG   = 180000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          line_tick = 1'b0;
  logic          cfg_user = 1'b0, cfg_valid = 1'b0;
  logic [CSW-1:0] cs_word = '0;
  logic          pcm_valid = 1'b0;
  logic          pcm_ready;
  logic [SW-1:0] pcm_left = '0, pcm_right = '0;
  logic          line_out;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  bmc_frame_tx #(.SAMPLE_W(SW), .CS_W(CSW)) i_bmc_frame_tx (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick),
    .cfg_user(cfg_user), .cfg_valid(cfg_valid), .cs_word(cs_word),
    .pcm_valid(pcm_valid), .pcm_ready(pcm_ready),
    .pcm_left(pcm_left), .pcm_right(pcm_right), .line_out(line_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_word(input logic [SW-1:0] s, input logic u,
                                           input logic v, input logic c);
    logic [31:0] w;
    w = '0;
    w[27:4] = s;
    w[28] = v;
    w[29] = u;
    w[30] = c;
    w[31] = ^w[30:4];
    return w;
  endfunction

  // half-cell levels, index = emission order
  function automatic logic [63:0] exp_halves(input logic [31:0] w, input int kind,
                                             input logic prev);
    logic [63:0] h;
    logic [7:0]  p;
    logic        lvl;
    p = (kind == 0) ? 8'b11101000 : (kind == 1) ? 8'b11100010 : 8'b11100100;
    for (int i = 0; i < 8; i++) h[i] = p[7-i] ^ prev;
    lvl = h[7];
    for (int k = 4; k < 32; k++) begin
      lvl = ~lvl;
      h[2*k] = lvl;
      lvl = lvl ^ w[k];
      h[2*k+1] = lvl;
    end
    return h;
  endfunction

  logic [SW-1:0] act_l = '0, act_r = '0, pend_l, pend_r;
  bit            pending = 0;
  bit            loaded_this_frame;
  logic          fr_u, fr_v;
  logic [63:0]   rec;
  logic          prev_lvl = 1'b0;
  logic [SW-1:0] last_dec [2];

  initial begin
    for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int dummy;
    dummy = $urandom(32'd4242);
    cs_word = $urandom();
    last_dec[0] = '0;
    last_dec[1] = '0;
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    check(line_out == 1'b0, "R1", "line in reset", 64'(line_out), 64'd0);
    check(pcm_ready == 1'b1, "R1", "ready in reset", 64'(pcm_ready), 64'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(line_out == 1'b0, "R1", "line after reset", 64'(line_out), 64'd0);
    check(pcm_ready == 1'b1, "R1", "ready after reset", 64'(pcm_ready), 64'd1);

    for (int t = 0; t < N_FRAMES * 128; t++) begin
      int  pos, frame, sub, kind;
      bit  offer;
      logic c_bit;
      logic [31:0] w, dw;
      logic [63:0] eh;
      pos   = t % 128;
      frame = (t / 128) % 192;
      // R9: ready mirrors the bench's view of the holding register
      check(pcm_ready == !pending, "R9", "ready level", 64'(pcm_ready), 64'(!pending));
      offer = !pending && (t / 128 >= 3) && (($urandom() % 100) < 2);
      if (pos == 0) begin
        loaded_this_frame = pending;
        if (pending) begin
          act_l = pend_l;
          act_r = pend_r;
          pending = 0;
        end
        if (t / 128 >= 2) begin
          cfg_user  = $urandom();
          cfg_valid = $urandom();
        end
        fr_u = cfg_user;
        fr_v = cfg_valid;
      end
      if (offer) begin
        pend_l = $urandom();
        pend_r = $urandom();
        if (($urandom() % 8) == 0) pend_l = '1;
        if (($urandom() % 8) == 0) pend_r = 24'h000001;
        pcm_left  = pend_l;
        pcm_right = pend_r;
        pcm_valid = 1'b1;
        pending   = 1;
      end
      line_tick = 1'b1;
      @(negedge clk);
      line_tick = 1'b0;
      pcm_valid = 1'b0;
      rec[pos % 64] = line_out;
      if (pos % 64 == 63) begin
        sub   = pos / 64;
        kind  = (sub == 1) ? 2 : (frame == 0) ? 0 : 1;
        c_bit = (frame < CSW) ? cs_word[frame] : 1'b0;
        w  = exp_word(sub ? act_r : act_l, fr_u, fr_v, c_bit);
        eh = exp_halves(w, kind, prev_lvl);
        // R2 R3: preamble type and polarity
        check(rec[7:0] == eh[7:0], "R3", "R2 preamble halves", 64'(rec[7:0]), 64'(eh[7:0]));
        // R4: cell boundary and mid-cell transitions
        check(rec[63:8] == eh[63:8], "R4", "data halves", 64'(rec[63:8]), 64'(eh[63:8]));
        dw = '0;
        for (int k = 4; k < 32; k++) dw[k] = rec[2*k] ^ rec[2*k+1];
        check(dw[27:4] == w[27:4], "R5", "R2 payload", 64'(dw[27:4]), 64'(w[27:4]));
        check(dw[29:28] == {fr_u, fr_v}, "R6", "user/valid", 64'(dw[29:28]), 64'({fr_u, fr_v}));
        check(dw[30] == c_bit, "R7", "status bit", 64'(dw[30]), 64'(c_bit));
        check(^dw[31:4] == 1'b0, "R8", "parity", 64'(dw[31:4]), 64'(w[31:4]));
        if (!loaded_this_frame && t >= 128)
          check(dw[27:4] == last_dec[sub], "R10", "repeat of previous pair",
                64'(dw[27:4]), 64'(last_dec[sub]));
        last_dec[sub] = dw[27:4];
        prev_lvl = rec[63];
      end
      begin
        int gap;
        logic hold_v;
        gap = $urandom() % 3;
        hold_v = line_out;
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          // R11: no tick, no change
          check(line_out == hold_v, "R11", "idle line", 64'(line_out), 64'(hold_v));
        end
      end
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule